// File: doc/BRIEF.md
# Paired Doubleword Access Sequencer

This block sits in the address stage of a load/store unit. It turns each incoming micro-op into a doubleword access request. A 16-byte (quad) access reaches the block as two micro-ops, a first iteration and a second iteration. The block keeps the address of the first iteration and uses it, advanced by one doubleword, for the second. The two halves therefore touch memory in increasing address order.

The block also chooses which register of the even/odd pair each iteration uses. The choice depends on the endianness bit. The block raises an alignment fault on the first iteration of a quad load that needs 16-byte alignment. That fault is raised before any access is issued, so no register is written. A faulted pair never issues its second half.

A separate output tells the interrupt logic whether asynchronous and trace interrupts may be taken. They are held off while a second iteration is in the output stage. Each result is registered and appears one clock after its micro-op.

Top module: `dw_pair_seq`

## Requirements
- R1: A micro-op with `in_quad` low appears on the outputs one cycle later with `acc_addr` equal to `in_ea`, `acc_reg` equal to `in_reg`, `acc_kind` equal to `in_kind`, and `align_fault` low, whatever the low address bits.
- R2: For a quad pair, the first iteration's access uses `in_ea` of that iteration. The second iteration's access uses the first iteration's address plus 8, wrapping modulo 2^AW, and ignores its own `in_ea`.
- R3: For quad micro-ops, the register output is `in_reg` with bit 0 forced. With `in_le` high, bit 0 is 1 on the first iteration and 0 on the second. With `in_le` low, the order is reversed.
- R4: A first-iteration quad load (`in_kind`=2'b00) with `in_le` high and a nonzero `in_ea[3:0]` gives `align_fault` high and `acc_valid` low. The same load with `in_le` low does not fault.
- R5: A first-iteration quad reserved load (`in_kind`=2'b10) with a nonzero `in_ea[3:0]` faults for either endianness. Quad stores (2'b01) and conditional stores (2'b11) never fault.
- R6: After a first iteration has faulted, the matching second iteration gives `acc_valid` low and `align_fault` low.
- R7: `async_ok` is low in the output cycle of an accepted second iteration, and high in every other cycle.
- R8: `flush` cancels any micro-op presented in the same cycle, so outputs are `acc_valid` low, `align_fault` low and `async_ok` high. It also discards a pending first iteration, so a following second iteration issues no access.
- R9: A second iteration with no pending first iteration issues no access.
- R10: While `rst` is high and in the cycle after it, `acc_valid` and `align_fault` are low and `async_ok` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Cancel the current micro-op and any pending pair state |
| in_valid | input | 1 | Micro-op present |
| in_kind | input | 2 | 00 load, 01 store, 10 reserved load, 11 conditional store |
| in_quad | input | 1 | Micro-op is one half of a 16-byte access |
| in_second | input | 1 | Micro-op is the second half |
| in_le | input | 1 | Little-endian mode |
| in_ea | input | AW | Effective address |
| in_reg | input | RW | Register number as given by the instruction |
| acc_valid | output | 1 | Doubleword access issued |
| acc_kind | output | 2 | Operation kind of the access |
| acc_addr | output | AW | Doubleword address |
| acc_reg | output | RW | Register of the pair used by this access |
| align_fault | output | 1 | Alignment exception request |
| async_ok | output | 1 | Asynchronous and trace interrupts may be taken |

## Verification
The bench builds the block with a 32-bit address and a 5-bit register number. With a 32-bit address, a first iteration at the top doubleword of the space can be driven, so the second iteration is seen to wrap to zero. The 5-bit register field lets the bench drive both even and odd base numbers and check that bit 0 is forced either way. Every kind, endianness, alignment, flush placement and orphan second iteration is driven at these values.

// File: rtl/dwp_pkg.sv
package dwp_pkg;

    typedef enum logic [1:0] {
        KIND_LD     = 2'b00,
        KIND_ST     = 2'b01,
        KIND_LDRES  = 2'b10,
        KIND_STCOND = 2'b11
    } dwp_kind_e;

    localparam int unsigned DW_BYTES   = 8;
    localparam int unsigned QUAD_BYTES = 16;
    localparam int unsigned QUAD_LSBS  = $clog2(QUAD_BYTES);

    typedef struct packed {
        logic issue;      // an access leaves the block
        logic fault;      // alignment exception request
        logic capture;    // first half accepted, remember its successor
        logic consume;    // second half presented, retire pending state
        logic use_saved;  // address comes from saved state
        logic reg_lsb;    // bit 0 of the paired register
    } dwp_ctl_t;

    // A quad access that must sit on a 16-byte boundary.
    function automatic logic needs_quad_align(dwp_kind_e kind, logic le);
        return (kind == KIND_LDRES) || ((kind == KIND_LD) && le);
    endfunction

    // Little-endian: first half odd, second half even; big-endian swaps.
    function automatic logic pair_lsb(logic le, logic second);
        return le ^ second;
    endfunction

endpackage

// File: rtl/dwp_classify.sv
module dwp_classify
    import dwp_pkg::*;
#(
    parameter int unsigned AW = 64
) (
    input  logic           flush,
    input  logic           in_valid,
    input  logic [1:0]     in_kind,
    input  logic           in_quad,
    input  logic           in_second,
    input  logic           in_le,
    input  logic [AW-1:0]  in_ea,
    input  logic           pend,
    input  logic           kill,
    output dwp_ctl_t       ctl
);
    localparam int unsigned LSBS = QUAD_LSBS;

    logic      active, first_h, second_h, misaligned;
    dwp_kind_e kind;

    always_comb begin
        kind       = dwp_kind_e'(in_kind);
        active     = in_valid && !flush;
        first_h    = active && in_quad && !in_second;
        second_h   = active && in_quad && in_second;
        misaligned = (in_ea[LSBS-1:0] != '0);

        ctl.fault     = first_h && needs_quad_align(kind, in_le) && misaligned;
        ctl.capture   = first_h;
        ctl.consume   = second_h;
        ctl.use_saved = second_h;
        ctl.reg_lsb   = pair_lsb(in_le, in_second);
        ctl.issue     = active && (!in_quad
                                   || (first_h && !ctl.fault)
                                   || (second_h && pend && !kill));
    end

    always_comb begin
        if (ctl.fault) begin
            AST_FAULT_ONLY_LOADS: assert (kind == KIND_LD || kind == KIND_LDRES); // R5
        end
    end

endmodule

// File: rtl/dwp_pair_state.sv
module dwp_pair_state
    import dwp_pkg::*;
#(
    parameter int unsigned AW = 64
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           flush,
    input  dwp_ctl_t       ctl,
    input  logic [AW-1:0]  in_ea,
    output logic           pend_q,
    output logic           kill_q,
    output logic [AW-1:0]  next_q
);
    localparam logic [AW-1:0] STEP = AW'(DW_BYTES);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            pend_q <= 1'b0;
            kill_q <= 1'b0;
            next_q <= '0;
        end else if (ctl.capture) begin
            pend_q <= 1'b1;
            kill_q <= ctl.fault;
            next_q <= in_ea + STEP;
        end else if (ctl.consume) begin
            pend_q <= 1'b0;
            kill_q <= 1'b0;
        end
    end

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!pend_q && !kill_q)); // R8

endmodule

// File: rtl/dwp_out_stage.sv
module dwp_out_stage
    import dwp_pkg::*;
#(
    parameter int unsigned AW = 64,
    parameter int unsigned RW = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  dwp_ctl_t       ctl,
    input  logic           in_quad,
    input  logic [1:0]     in_kind,
    input  logic [AW-1:0]  in_ea,
    input  logic [RW-1:0]  in_reg,
    input  logic [AW-1:0]  next_q,
    output logic           acc_valid,
    output logic [1:0]     acc_kind,
    output logic [AW-1:0]  acc_addr,
    output logic [RW-1:0]  acc_reg,
    output logic           align_fault,
    output logic           async_ok
);
    logic [AW-1:0] addr_d;
    logic [RW-1:0] reg_d;

    always_comb begin
        addr_d = ctl.use_saved ? next_q : in_ea;
        if (in_quad) begin
            reg_d = {in_reg[RW-1:1], ctl.reg_lsb};
        end else begin
            reg_d = in_reg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_valid   <= 1'b0;
            acc_kind    <= '0;
            acc_addr    <= '0;
            acc_reg     <= '0;
            align_fault <= 1'b0;
            async_ok    <= 1'b1;
        end else begin
            acc_valid   <= ctl.issue;
            acc_kind    <= ctl.issue ? in_kind : 2'b00;
            acc_addr    <= ctl.issue ? addr_d : '0;
            acc_reg     <= ctl.issue ? reg_d : '0;
            align_fault <= ctl.fault;
            async_ok    <= !ctl.consume;
        end
    end

    AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        align_fault |-> !acc_valid); // R4

endmodule

// File: rtl/dw_pair_seq.sv
module dw_pair_seq
    import dwp_pkg::*;
#(
    parameter int unsigned AW = 64,
    parameter int unsigned RW = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           flush,
    input  logic           in_valid,
    input  logic [1:0]     in_kind,
    input  logic           in_quad,
    input  logic           in_second,
    input  logic           in_le,
    input  logic [AW-1:0]  in_ea,
    input  logic [RW-1:0]  in_reg,
    output logic           acc_valid,
    output logic [1:0]     acc_kind,
    output logic [AW-1:0]  acc_addr,
    output logic [RW-1:0]  acc_reg,
    output logic           align_fault,
    output logic           async_ok
);
    dwp_ctl_t      ctl;
    logic          pend_q, kill_q;
    logic [AW-1:0] next_q;

    dwp_classify #(.AW(AW)) u_classify (
        .flush     (flush),
        .in_valid  (in_valid),
        .in_kind   (in_kind),
        .in_quad   (in_quad),
        .in_second (in_second),
        .in_le     (in_le),
        .in_ea     (in_ea),
        .pend      (pend_q),
        .kill      (kill_q),
        .ctl       (ctl)
    );

    dwp_pair_state #(.AW(AW)) u_state (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .ctl    (ctl),
        .in_ea  (in_ea),
        .pend_q (pend_q),
        .kill_q (kill_q),
        .next_q (next_q)
    );

    dwp_out_stage #(.AW(AW), .RW(RW)) u_out (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ctl),
        .in_quad     (in_quad),
        .in_kind     (in_kind),
        .in_ea       (in_ea),
        .in_reg      (in_reg),
        .next_q      (next_q),
        .acc_valid   (acc_valid),
        .acc_kind    (acc_kind),
        .acc_addr    (acc_addr),
        .acc_reg     (acc_reg),
        .align_fault (align_fault),
        .async_ok    (async_ok)
    );

    AST_SECOND_HOLDS_ASYNC: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !flush && in_quad && in_second) |=> !async_ok); // R7

    AST_KILLED_SECOND_SILENT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !flush && in_quad && in_second && kill_q) |=> (!acc_valid && !align_fault)); // R6

    AST_SINGLE_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !flush && !in_quad) |=> !align_fault); // R1

    AST_ORPHAN_SECOND: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !flush && in_quad && in_second && !pend_q) |=> !acc_valid); // R9

endmodule

// File: tb/dw_pair_seq_test.sv
module dw_pair_seq_test;
    localparam int unsigned AW = 32;
    localparam int unsigned RW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          flush = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    in_kind = 2'b00;
    logic          in_quad = 1'b0;
    logic          in_second = 1'b0;
    logic          in_le = 1'b0;
    logic [AW-1:0] in_ea = '0;
    logic [RW-1:0] in_reg = '0;
    logic          acc_valid, align_fault, async_ok;
    logic [1:0]    acc_kind;
    logic [AW-1:0] acc_addr;
    logic [RW-1:0] acc_reg;

    always #2 clk = ~clk;   // 250 MHz

    dw_pair_seq #(.AW(AW), .RW(RW)) uut (
        .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
        .in_kind(in_kind), .in_quad(in_quad), .in_second(in_second),
        .in_le(in_le), .in_ea(in_ea), .in_reg(in_reg),
        .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr),
        .acc_reg(acc_reg), .align_fault(align_fault), .async_ok(async_ok)
    );

    typedef struct {
        logic          valid;
        logic          fault;
        logic          async;
        logic [1:0]    kind;
        logic [AW-1:0] addr;
        logic [RW-1:0] rg;
        string         req;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // reference model state
    logic          m_pend = 1'b0;
    logic          m_kill = 1'b0;
    logic [AW-1:0] m_next = '0;

    task automatic drive(input logic v, input logic [1:0] k, input logic q,
                         input logic s, input logic le, input logic [AW-1:0] ea,
                         input logic [RW-1:0] rg, input logic fl, input string req);
        exp_t e;
        logic act, fst, snd, need, flt;
        @(negedge clk);
        flush = fl; in_valid = v; in_kind = k; in_quad = q;
        in_second = s; in_le = le; in_ea = ea; in_reg = rg;
        act  = v && !fl;
        fst  = act && q && !s;
        snd  = act && q && s;
        need = (k == 2'b10) || (k == 2'b00 && le);
        flt  = fst && need && (ea[3:0] != 4'h0);
        e.valid = act && (!q || (fst && !flt) || (snd && m_pend && !m_kill));
        e.fault = flt;
        e.async = !snd;
        e.kind  = k;
        e.addr  = snd ? m_next : ea;
        if (!q)            e.rg = rg;
        else if (le == s)  e.rg = {rg[RW-1:1], 1'b0};
        else               e.rg = {rg[RW-1:1], 1'b1};
        e.req = req;
        exp_q.push_back(e);
        if (fl) begin
            m_pend = 1'b0; m_kill = 1'b0; m_next = '0;
        end else if (fst) begin
            m_pend = 1'b1; m_kill = flt; m_next = ea + 32'd8;
        end else if (snd) begin
            m_pend = 1'b0; m_kill = 1'b0;
        end
    endtask

    task automatic idle(input string req);
        drive(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0, req);
    endtask

    // monitor / scoreboard
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_cmp++;
            if (acc_valid !== e.valid || align_fault !== e.fault || async_ok !== e.async ||
                (e.valid && (acc_addr !== e.addr || acc_reg !== e.rg || acc_kind !== e.kind))) begin
                n_bad++;
                $display("FAIL %s: got v=%b f=%b a=%b k=%0d addr=%h reg=%0d exp v=%b f=%b a=%b k=%0d addr=%h reg=%0d",
                         e.req, acc_valid, align_fault, async_ok, acc_kind, acc_addr, acc_reg,
                         e.valid, e.fault, e.async, e.kind, e.addr, e.rg);
            end
        end
    end

    task automatic check_reset(input string req);
        n_cmp++;
        if (acc_valid !== 1'b0 || align_fault !== 1'b0 || async_ok !== 1'b1) begin
            n_bad++;
            $display("FAIL %s: got v=%b f=%b a=%b exp v=0 f=0 a=1", req,
                     acc_valid, align_fault, async_ok);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset("R10 during reset");
        rst = 1'b0;
        idle("R10 after reset");

        // R1 single accesses, including misaligned
        drive(1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 32'h0000_1003, 5'd9, 1'b0, "R1 single load LE misaligned");
        drive(1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 32'h0000_2005, 5'd4, 1'b0, "R1 single reserved load");
        drive(1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 32'h0000_3000, 5'd31, 1'b0, "R1 single store");

        // R2 R3 R7 little-endian quad load, aligned
        drive(1'b1, 2'b00, 1'b1, 1'b0, 1'b1, 32'h0000_1000, 5'd6, 1'b0, "R2 R3 LE first");
        drive(1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 32'h0000_FFF0, 5'd6, 1'b0, "R2 R3 R7 LE second");
        // big-endian quad store, with an idle gap
        drive(1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 32'h0000_4008, 5'd7, 1'b0, "R3 BE first odd base");
        idle("R7 idle gap");
        drive(1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 32'h0, 5'd7, 1'b0, "R2 R3 R7 BE second");

        // R4 LE misaligned quad load faults, second silent
        drive(1'b1, 2'b00, 1'b1, 1'b0, 1'b1, 32'h0000_5008, 5'd10, 1'b0, "R4 LE misaligned fault");
        drive(1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 32'h0000_5010, 5'd10, 1'b0, "R6 suppressed second");
        // R4 BE misaligned quad load: no fault
        drive(1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 32'h0000_6004, 5'd12, 1'b0, "R4 BE misaligned no fault");
        drive(1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 32'h0, 5'd12, 1'b0, "R4 BE second");

        // R5 reserved load faults in BE; conditional store never
        drive(1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 32'h0000_7008, 5'd14, 1'b0, "R5 reserved BE fault");
        drive(1'b1, 2'b10, 1'b1, 1'b1, 1'b0, 32'h0, 5'd14, 1'b0, "R6 reserved second");
        drive(1'b1, 2'b11, 1'b1, 1'b0, 1'b1, 32'h0000_8008, 5'd16, 1'b0, "R5 cond store no fault");
        drive(1'b1, 2'b11, 1'b1, 1'b1, 1'b1, 32'h0, 5'd16, 1'b0, "R5 cond store second");
        drive(1'b1, 2'b10, 1'b1, 1'b0, 1'b1, 32'h0000_9000, 5'd18, 1'b0, "R5 reserved aligned");
        drive(1'b1, 2'b10, 1'b1, 1'b1, 1'b1, 32'h0, 5'd18, 1'b0, "R5 reserved aligned second");

        // R8 flush: same-cycle cancel, then pending discarded
        drive(1'b1, 2'b00, 1'b1, 1'b0, 1'b1, 32'h0000_A000, 5'd20, 1'b0, "R8 first before flush");
        drive(1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 32'h0000_A000, 5'd20, 1'b1, "R8 flush cancels second");
        drive(1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 32'h0000_A000, 5'd20, 1'b0, "R8 second after flush");
        drive(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 32'h0000_B000, 5'd1, 1'b1, "R8 flush single");

        // R9 orphan second
        drive(1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 32'h0000_C000, 5'd2, 1'b0, "R9 orphan second");

        // R2 wrap at top of address space
        drive(1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFF8, 5'd22, 1'b0, "R2 wrap first");
        drive(1'b1, 2'b01, 1'b1, 1'b1, 1'b1, 32'h0, 5'd22, 1'b0, "R2 wrap second");

        // R10 reset mid-pair clears pending
        drive(1'b1, 2'b00, 1'b1, 1'b0, 1'b1, 32'h0000_D000, 5'd24, 1'b0, "R10 first before reset");
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(posedge clk); #1;
        check_reset("R10 reset mid pair");
        @(negedge clk);
        rst = 1'b0;
        m_pend = 1'b0; m_kill = 1'b0;
        drive(1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 32'h0000_D000, 5'd24, 1'b0, "R9 second after reset");
        idle("R7 final idle");
        idle("R7 final idle");

        @(posedge clk); #2;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule